// File: doc/BRIEF.md
# Bus-Mapped Triple Output Latch

This block is a write-only peripheral for an 8-bit processor bus that uses a two-phase bus clock. The processor stores a byte at one of three addresses and the block keeps that byte on a dedicated group of eight output lines until the same address is written again. Three such groups give 24 output lines that can drive LEDs, a tone generator or any other static control input.

Every bus input is first brought into a fast local clock domain. Address decoding has two levels. The top three address bits must match a configured 8 KB region, and two low address bits then pick one of the three registers. The write is committed when the bus clock falls at the end of the cycle, not when it rises. At that point the write data has settled, so data that arrives late in the high phase is still captured correctly. Addressing and write qualification are sampled while the bus clock is high, so a bus that moves to a new address after the falling edge cannot redirect a write that has already been decided.

Top module: `bus_out_latch`

## Requirements
- R1: A write takes effect only when addr_i[15:13] equals 3'b101, which is the window 0xA000 to 0xBFFF. A write anywhere else changes no output. Address bits 12 to 2 are not decoded, so the three registers repeat throughout the window.
- R2: addr_i[1:0] selects the register. Code 0 drives port_o[7:0], code 1 drives port_o[15:8] and code 2 drives port_o[23:16]. One bus write updates at most one register. upd_o[i] is high for exactly one clk cycle, in the same cycle in which register i takes its new value.
- R3: A cycle with rw_n_i high is a read and changes no register.
- R4: A register takes its new value on the third rising clk edge after phi2_i falls. The edge that first samples phi2_i low counts as the first.
- R5: The committed byte is the value of data_i at the last clk edge at which phi2_i is still sampled high. Values on data_i earlier in the high phase have no effect on the result.
- R6: Changes to addr_i, rw_n_i or data_i after phi2_i falls do not change which register is written or what is written.
- R7: A write to sub-select code 3 inside the window changes no output and raises no update pulse.
- R8: A synchronous active-high rst clears all three registers to 0x00 and holds upd_o at zero.
- R9: Each register keeps its value on every cycle in which its own update pulse is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sampling clock, at least 8 times the bus clock rate |
| rst | input | 1 | Synchronous active-high reset |
| phi2_i | input | 1 | Bus clock: low in the first half of a cycle, high in the second |
| rw_n_i | input | 1 | High for a read, low for a write |
| addr_i | input | 16 | Bus address |
| data_i | input | 8 | Bus data |
| port_o | output | 24 | Three 8-bit output registers, register 0 in the low byte |
| upd_o | output | 3 | One-cycle pulse per register when it is written |

## Verification
The bench puts garbage on the data bus at the start of each high phase. A design that captured data at the rising edge would therefore latch the wrong byte. In some cycles the address moves to a neighbouring register as soon as the bus clock falls. A design that decoded late would write the neighbour instead of the intended register. Reads inside the window, writes to sub-select code 3, writes outside the region and writes to a mirrored address all probe the decoder, so an incomplete or wrong decode shows up as a spurious update pulse. One write is timed edge by edge to confirm the three-edge latency. A reset in the middle of the run must return every port to zero.

// File: rtl/bol_pkg.sv
package bol_pkg;
    parameter int ADDR_W    = 16;
    parameter int DATA_W    = 8;
    parameter int NUM_PORTS = 3;
    parameter int SEL_W     = 2;
    parameter int REGION_W  = 3;
    parameter int SYNC_LEN  = 2;

    localparam int BUS_W = 2 + REGION_W + SEL_W + DATA_W;

    typedef logic [DATA_W-1:0] byte_t;
    typedef logic [SEL_W-1:0]  sel_t;
    typedef logic [REGION_W-1:0] region_t;

    typedef struct packed {
        logic  phi_prev;
        logic  qual;
        sel_t  sel;
        byte_t data;
    } cap_state_t;
endpackage

// File: rtl/bol_sync.sv
module bol_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < STAGES; i++) begin
            if (rst) stage_q[i] <= '0;
            else     stage_q[i] <= stage_d[i];
        end
    end

    assign dout = stage_q[STAGES-1];
endmodule

// File: rtl/bol_capture.sv
module bol_capture
    import bol_pkg::*;
#(
    parameter region_t REGION = 3'd5
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    phi_s,
    input  logic    rw_s,
    input  region_t region_s,
    input  sel_t    sel_s,
    input  byte_t   data_s,
    output logic    commit,
    output sel_t    commit_sel,
    output byte_t   commit_data
);
    cap_state_t cap_d, cap_q;

    always_comb begin
        cap_d          = cap_q;
        cap_d.phi_prev = phi_s;
        if (phi_s) begin
            cap_d.qual = !rw_s && (region_s == REGION) &&
                         (int'(sel_s) < NUM_PORTS);
            cap_d.sel  = sel_s;
            cap_d.data = data_s;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cap_q <= '0;
        else     cap_q <= cap_d;
    end

    assign commit      = cap_q.phi_prev && !phi_s && cap_q.qual;
    assign commit_sel  = cap_q.sel;
    assign commit_data = cap_q.data;

    assert_write_only_R3: assert property (@(posedge clk) disable iff (rst)
        commit |-> !$past(rw_s));
    assert_fall_commit_R4: assert property (@(posedge clk) disable iff (rst)
        commit |-> ($past(phi_s) && !phi_s));
    assert_region_R1: assert property (@(posedge clk) disable iff (rst)
        commit |-> ($past(region_s) == REGION));
    assert_sub_ignored_R7: assert property (@(posedge clk) disable iff (rst)
        commit |-> (int'(commit_sel) < NUM_PORTS));
endmodule

// File: rtl/bol_ports.sv
module bol_ports
    import bol_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        commit,
    input  sel_t                        commit_sel,
    input  byte_t                       commit_data,
    output logic [NUM_PORTS*DATA_W-1:0] port_flat,
    output logic [NUM_PORTS-1:0]        upd
);
    typedef struct packed {
        logic [NUM_PORTS-1:0]            upd;
        logic [NUM_PORTS-1:0][DATA_W-1:0] regs;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d     = bank_q;
        bank_d.upd = '0;
        for (int i = 0; i < NUM_PORTS; i++) begin
            if (commit && (int'(commit_sel) == i)) begin
                bank_d.regs[i] = commit_data;
                bank_d.upd[i]  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) bank_q <= '0;
        else     bank_q <= bank_d;
    end

    generate
        for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
            assign port_flat[g*DATA_W +: DATA_W] = bank_q.regs[g];

            assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
                !bank_q.upd[g] |-> (bank_q.regs[g] == $past(bank_q.regs[g])));
            assert_data_R5: assert property (@(posedge clk) disable iff (rst)
                bank_q.upd[g] |-> (bank_q.regs[g] == $past(commit_data)));
        end
    endgenerate

    assign upd = bank_q.upd;

    assert_one_port_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(upd));
    assert_reset_R8: assert property (@(posedge clk)
        rst |=> (port_flat == '0 && upd == '0));
endmodule

// File: rtl/bus_out_latch.sv
module bus_out_latch
    import bol_pkg::*;
#(
    parameter region_t REGION = 3'd5
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        phi2_i,
    input  logic                        rw_n_i,
    input  logic [ADDR_W-1:0]           addr_i,
    input  logic [DATA_W-1:0]           data_i,
    output logic [NUM_PORTS*DATA_W-1:0] port_o,
    output logic [NUM_PORTS-1:0]        upd_o
);
    logic [BUS_W-1:0] bus_raw, bus_s;
    logic             phi_s, rw_s;
    region_t          region_s;
    sel_t             sel_s;
    byte_t            data_s;
    logic             commit;
    sel_t             commit_sel;
    byte_t            commit_data;
    logic             unused_addr_mid;

    assign unused_addr_mid = ^addr_i[ADDR_W-REGION_W-1:SEL_W];

    assign bus_raw = {phi2_i, rw_n_i, addr_i[ADDR_W-1 -: REGION_W],
                      addr_i[SEL_W-1:0], data_i};

    bol_sync #(.W(BUS_W), .STAGES(SYNC_LEN)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  (bus_raw),
        .dout (bus_s)
    );

    assign {phi_s, rw_s, region_s, sel_s, data_s} = bus_s;

    bol_capture #(.REGION(REGION)) u_cap (
        .clk         (clk),
        .rst         (rst),
        .phi_s       (phi_s),
        .rw_s        (rw_s),
        .region_s    (region_s),
        .sel_s       (sel_s),
        .data_s      (data_s),
        .commit      (commit),
        .commit_sel  (commit_sel),
        .commit_data (commit_data)
    );

    bol_ports u_ports (
        .clk         (clk),
        .rst         (rst),
        .commit      (commit),
        .commit_sel  (commit_sel),
        .commit_data (commit_data),
        .port_flat   (port_o),
        .upd         (upd_o)
    );
endmodule

// File: tb/sim_bus_out_latch.sv
`timescale 1ns/1ps
module sim_bus_out_latch;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        phi2 = 1'b0;
    logic        rw_n = 1'b1;
    logic [15:0] addr = 16'h0000;
    logic [7:0]  data = 8'h00;
    logic [23:0] port_o;
    logic [2:0]  upd_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    bus_out_latch u0 (
        .clk(clk), .rst(rst), .phi2_i(phi2), .rw_n_i(rw_n),
        .addr_i(addr), .data_i(data), .port_o(port_o), .upd_o(upd_o)
    );

    // reference model: history of bus inputs seen at each clock edge
    logic        h_phi [1:3];
    logic        h_rw  [1:3];
    logic [15:0] h_adr [1:3];
    logic [7:0]  h_dat [1:3];
    logic [7:0]  m_port [3];
    logic [2:0]  m_upd;

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 1; i <= 3; i++) begin
                h_phi[i] = 0; h_rw[i] = 0; h_adr[i] = 0; h_dat[i] = 0;
            end
            for (int i = 0; i < 3; i++) m_port[i] = 8'h00;
            m_upd = 3'b000;
        end else begin
            m_upd = 3'b000;
            if (!h_phi[2] && h_phi[3] && !h_rw[3] &&
                h_adr[3][15:13] == 3'b101 && h_adr[3][1:0] != 2'd3) begin
                m_port[h_adr[3][1:0]] = h_dat[3];
                m_upd[h_adr[3][1:0]]  = 1'b1;
            end
            for (int i = 3; i > 1; i--) begin
                h_phi[i] = h_phi[i-1]; h_rw[i] = h_rw[i-1];
                h_adr[i] = h_adr[i-1]; h_dat[i] = h_dat[i-1];
            end
            h_phi[1] = phi2; h_rw[1] = rw_n; h_adr[1] = addr; h_dat[1] = data;
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (port_o !== {m_port[2], m_port[1], m_port[0]}) begin
                errors++;
                $display("FAIL R9 port value: got %h expected %h", port_o,
                         {m_port[2], m_port[1], m_port[0]});
            end
            checks++;
            if (upd_o !== m_upd) begin
                errors++;
                $display("FAIL R2 update pulse: got %b expected %b", upd_o, m_upd);
            end
        end
    end

    task automatic check_port(input int idx, input logic [7:0] exp, input string tag);
        checks++;
        if (port_o[idx*8 +: 8] !== exp) begin
            errors++;
            $display("FAIL %s port%0d: got %h expected %h", tag, idx,
                     port_o[idx*8 +: 8], exp);
        end
    endtask

    // one bus cycle: 8 clocks low, 8 clocks high, 6 clocks after the fall
    task automatic bus_cycle(input logic [15:0] a, input logic rd, input logic [7:0] d,
                             input bit move_after);
        @(negedge clk);
        phi2 = 0; addr = a; rw_n = rd; data = ~d;
        repeat (8) @(negedge clk);
        phi2 = 1;
        repeat (3) @(negedge clk);
        data = d;
        repeat (5) @(negedge clk);
        phi2 = 0;
        if (move_after) begin
            addr = a ^ 16'h0001; data = 8'hEE; rw_n = 0;
        end
        repeat (6) @(negedge clk);
        rw_n = 1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        check_port(0, 8'h00, "R8"); check_port(1, 8'h00, "R8"); check_port(2, 8'h00, "R8");
        rst = 0;
        repeat (2) @(negedge clk);

        // R5: late data, R2: selection
        bus_cycle(16'hA000, 0, 8'h3C, 0);
        check_port(0, 8'h3C, "R5");
        bus_cycle(16'hA001, 0, 8'hA5, 0);
        bus_cycle(16'hA002, 0, 8'h81, 0);
        check_port(1, 8'hA5, "R2"); check_port(2, 8'h81, "R2"); check_port(0, 8'h3C, "R2");

        // R3: read in window
        bus_cycle(16'hA000, 1, 8'hFF, 0);
        check_port(0, 8'h3C, "R3");

        // R1: outside region, and mirrored address inside region
        bus_cycle(16'h2000, 0, 8'h77, 0);
        bus_cycle(16'hC001, 0, 8'h77, 0);
        check_port(0, 8'h3C, "R1"); check_port(1, 8'hA5, "R1");
        bus_cycle(16'hBFF1, 0, 8'h42, 0);
        check_port(1, 8'h42, "R1");

        // R7: sub-select code 3
        bus_cycle(16'hA003, 0, 8'h99, 0);
        check_port(0, 8'h3C, "R7"); check_port(1, 8'h42, "R7"); check_port(2, 8'h81, "R7");

        // R6: address moves to a neighbour after the fall
        bus_cycle(16'hA000, 0, 8'h11, 1);
        check_port(0, 8'h11, "R6"); check_port(1, 8'h42, "R6");

        // R4: edge-exact latency
        @(negedge clk);
        phi2 = 0; addr = 16'hA002; rw_n = 0; data = 8'h00;
        repeat (8) @(negedge clk);
        phi2 = 1; data = 8'h5E;
        repeat (8) @(negedge clk);
        phi2 = 0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check_port(2, 8'h81, "R4");
        @(posedge clk); @(negedge clk);
        check_port(2, 8'h5E, "R4");
        rw_n = 1;
        repeat (6) @(negedge clk);

        // R9: repeated writes to one port leave others alone
        bus_cycle(16'hA001, 0, 8'h01, 0);
        bus_cycle(16'hA001, 0, 8'hFE, 0);
        check_port(1, 8'hFE, "R9"); check_port(0, 8'h11, "R9"); check_port(2, 8'h5E, "R9");

        // R8: reset mid-run
        @(negedge clk); rst = 1;
        @(negedge clk); @(negedge clk);
        check_port(0, 8'h00, "R8"); check_port(1, 8'h00, "R8"); check_port(2, 8'h00, "R8");
        rst = 0;
        bus_cycle(16'hA002, 0, 8'hC3, 0);
        check_port(2, 8'hC3, "R2");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule